// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the master end of an external bus on which address and data share one set of lines. A transfer begins by driving the address with the address strobe high. The strobe then falls so that external logic can latch the address. After a hold interval, either the read strobe or one or both byte-lane write strobes go low. On a write the port carries the write data. On a read it is released so the target can drive it. The block also runs a bus-release handshake, so that another master can take the bus between transfers.

The block runs on a clock at twice the bus rate. One clock of this block is one half-period ("tick") of the bus clock, and every interval below is given in ticks. The internal side is a valid/ready request carrying address, write data, byte enables and direction. Completion is a one-tick `rsp_done` pulse, and read data is held on `rsp_data` from that pulse onward. Timing options (`cfg_as`, `cfg_ah`, `cfg_idle`, `cfg_wait`) are sampled when a request is accepted. Only output-enable signals are produced for the pads; the pad drivers themselves sit outside the block.

Top module: `mxb_bus_master`

## Requirements
- R1: After acceptance, `ad_oe` is 1, `ad_out` carries the request address and `astb` is 1 for exactly 1+2*cfg_as ticks, and then `astb` falls.
- R2: After `astb` falls, the address stays driven with all strobes high for exactly 1+2*cfg_ah ticks before a strobe falls.
- R3: The strobe stays low for L ticks. L is found by starting at 2*(1+cfg_wait) and adding 2 for as long as L does not exceed the last strobe tick on which `wait_req` was 1. `wait_req` is sampled only on strobe ticks 2*(1+cfg_wait), 2*(1+cfg_wait)+2, and so on, counted from 1.
- R4: A strobe is never low while `astb` is 1. `astb` stays 0 for the first tick after the strobe rises and is 1 from the second tick on.
- R5: On a read, `rd_n` is low, both write strobes stay high, and `ad_oe` is 0 from the strobe fall to the end of the transfer. Recovery after `rd_n` rises lasts 2+2*cfg_idle ticks, counting the `rsp_done` tick. `rsp_data` shows the `ad_in` value sampled on the last tick of the strobe.
- R6: On a write, `rd_n` stays high. `wr_lo_n` goes low only if `req_be[0]` is 1 and `wr_hi_n` goes low only if `req_be[1]` is 1. `ad_out` carries the write data with `ad_oe` 1 from the strobe fall until 2 ticks after the strobe rises, and `rsp_done` comes in the second of those ticks.
- R7: `rsp_done` is a single-tick pulse. `req_ready` is 1 on the tick after it unless `hold_req` is 1.
- R8: `hold_ack` rises no sooner than 4 ticks after `hold_req` is first driven high, and never during a transfer. `ad_oe` and `ctl_oe` are 0 on the tick before `hold_ack` rises and while it is high.
- R9: One tick after `hold_req` is driven low, `hold_ack` is 0 and `ctl_oe` is still 0. One tick later `ctl_oe` is 1.
- R10: A request presented while the bus is released is not started: `req_ready` is 0, `astb` stays 1 and the port is not driven until the release ends, and the request is then carried out.
- R11: In reset, `astb`, `rd_n`, `wr_lo_n`, `wr_hi_n` and `ctl_oe` are 1, and `ad_oe`, `hold_ack` and `rsp_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_as | input | 1 | Extra address setup wait |
| cfg_ah | input | 1 | Extra address hold wait |
| cfg_idle | input | 1 | Extra idle clock after a read |
| cfg_wait | input | WW | Programmed data wait clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | Transfer address |
| req_wdata | input | DW | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane |
| rsp_done | output | 1 | Transfer complete pulse |
| rsp_data | output | DW | Captured read data |
| ad_in | input | DW | Shared port input value |
| ad_out | output | DW | Shared port output value |
| ad_oe | output | 1 | Shared port drive enable |
| astb | output | 1 | Address strobe, address latched on fall |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Lower-lane write strobe, active low |
| wr_hi_n | output | 1 | Upper-lane write strobe, active low |
| ctl_oe | output | 1 | Strobe drive enable |
| wait_req | input | 1 | External wait request, active high |
| hold_req | input | 1 | Bus release request |
| hold_ack | output | 1 | Bus released |

## Verification
The assertions assume that `hold_req` changes only between clock edges and that a requester keeps `req_valid` and its fields stable until acceptance. They also assume that nonzero byte enables are given on writes, since a write with no lanes produces no strobe. The stimulus drives every input at the falling clock edge. It presents each request and holds it until `req_ready` is seen, and it sweeps only the byte-enable values 1 to 3. `wait_req` is driven only while a strobe is low. It is derived from the tick count in that strobe, so the sampled points land at known positions.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_AHOLD,
    ST_STRB,
    ST_RECOV,
    ST_FLOAT,
    ST_GRANT,
    ST_REL
  } mxb_state_e;
endpackage

// File: rtl/mxb_hold_age.sv
module mxb_hold_age #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  output logic hold_ripe
);
  localparam int AGEW = $clog2(LIMIT + 1);

  logic [AGEW-1:0] age_q, age_d;

  always_comb begin
    age_d = age_q;
    if (!hold_req) begin
      age_d = '0;
    end else if (age_q != AGEW'(LIMIT)) begin
      age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assign hold_ripe = (age_q == AGEW'(LIMIT));
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
  import mxb_pkg::*;
#(
  parameter int WW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_wr,
  input  logic          cfg_as,
  input  logic          cfg_ah,
  input  logic          cfg_idle,
  input  logic [WW-1:0] cfg_wait,
  input  logic          wait_req,
  input  logic          hold_req,
  input  logic          hold_ripe,
  output mxb_state_e    state,
  output logic          rec_first,
  output logic          wr_cur,
  output logic          req_ready,
  output logic          load,
  output logic          cap_en,
  output logic          done
);
  localparam int CNTW = WW + 2;

  mxb_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            first_q, first_d;
  logic            wr_q, ah_q, idle_q;
  logic [WW-1:0]   cw_q;

  assign req_ready = (state_q == ST_IDLE) && !hold_req;
  assign load      = req_valid && req_ready;
  assign done      = (state_q == ST_RECOV) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    first_d = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hold_req) begin
          state_d = ST_FLOAT;
        end else if (req_valid) begin
          state_d = ST_SETUP;
          cnt_d   = cfg_as ? CNTW'(2) : '0;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_AHOLD;
          cnt_d   = ah_q ? CNTW'(2) : '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_AHOLD: begin
        if (cnt_q == '0) begin
          state_d = ST_STRB;
          cnt_d   = {1'b0, cw_q, 1'b1};
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_STRB: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (wait_req) begin
          cnt_d = CNTW'(1);
        end else begin
          state_d = ST_RECOV;
          cap_en  = !wr_q;
          first_d = 1'b1;
          cnt_d   = (!wr_q && idle_q) ? CNTW'(3) : CNTW'(1);
        end
      end
      ST_RECOV: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_FLOAT: begin
        if (!hold_req)     state_d = ST_IDLE;
        else if (hold_ripe) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        if (!hold_req) state_d = ST_REL;
      end
      ST_REL:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      ah_q   <= 1'b0;
      idle_q <= 1'b0;
      cw_q   <= '0;
    end else if (load) begin
      wr_q   <= req_wr;
      ah_q   <= cfg_ah;
      idle_q <= cfg_idle;
      cw_q   <= cfg_wait;
    end
  end

  assign state     = state_q;
  assign rec_first = first_q;
  assign wr_cur    = wr_q;
endmodule

// File: rtl/mxb_datapath.sv
module mxb_datapath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  input  logic          cap_en,
  input  logic [DW-1:0] ad_in,
  input  logic          sel_data,
  output logic [DW-1:0] ad_out,
  output logic [1:0]    be_cur,
  output logic [DW-1:0] rsp_data
);
  logic [DW-1:0] addr_q, wdata_q, rdata_q;
  logic [1:0]    be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (load) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

  assign ad_out   = sel_data ? wdata_q : addr_q;
  assign be_cur   = be_q;
  assign rsp_data = rdata_q;
endmodule

// File: rtl/mxb_bus_master.sv
module mxb_bus_master
  import mxb_pkg::*;
#(
  parameter int DW         = 16,
  parameter int WW         = 2,
  parameter int HOLD_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_as,
  input  logic          cfg_ah,
  input  logic          cfg_idle,
  input  logic [WW-1:0] cfg_wait,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          astb,
  output logic          rd_n,
  output logic          wr_lo_n,
  output logic          wr_hi_n,
  output logic          ctl_oe,
  input  logic          wait_req,
  input  logic          hold_req,
  output logic          hold_ack
);
  logic       rst_s1, rst_s2;
  mxb_state_e state;
  logic       rec_first, wr_cur, load, cap_en, hold_ripe;
  logic [1:0] be_cur;
  logic       in_strb, in_addr, in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  mxb_hold_age #(.LIMIT(HOLD_TICKS)) u_age (
    .clk(clk), .rst_n(rst_s2), .hold_req(hold_req), .hold_ripe(hold_ripe)
  );

  mxb_seq #(.WW(WW)) u_seq (
    .clk(clk), .rst_n(rst_s2), .req_valid(req_valid), .req_wr(req_wr),
    .cfg_as(cfg_as), .cfg_ah(cfg_ah), .cfg_idle(cfg_idle), .cfg_wait(cfg_wait),
    .wait_req(wait_req), .hold_req(hold_req), .hold_ripe(hold_ripe),
    .state(state), .rec_first(rec_first), .wr_cur(wr_cur),
    .req_ready(req_ready), .load(load), .cap_en(cap_en), .done(rsp_done)
  );

  assign in_strb = (state == ST_STRB);
  assign in_addr = (state == ST_SETUP) || (state == ST_AHOLD);
  assign in_data = (in_strb || (state == ST_RECOV)) && wr_cur;

  mxb_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_s2), .load(load), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .cap_en(cap_en), .ad_in(ad_in),
    .sel_data(in_data), .ad_out(ad_out), .be_cur(be_cur), .rsp_data(rsp_data)
  );

  assign ad_oe    = in_addr || in_data;
  assign astb     = !((state == ST_AHOLD) || in_strb ||
                      ((state == ST_RECOV) && rec_first));
  assign rd_n     = !(in_strb && !wr_cur);
  assign wr_lo_n  = !(in_strb && wr_cur && be_cur[0]);
  assign wr_hi_n  = !(in_strb && wr_cur && be_cur[1]);
  assign ctl_oe   = !((state == ST_FLOAT) || (state == ST_GRANT) || (state == ST_REL));
  assign hold_ack = (state == ST_GRANT);
endmodule

// File: rtl/mxb_bus_master_chk.sv
module mxb_bus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic ad_oe,
  input logic astb,
  input logic rd_n,
  input logic wr_lo_n,
  input logic wr_hi_n,
  input logic ctl_oe,
  input logic hold_req,
  input logic hold_ack,
  input logic req_ready,
  input logic rsp_done
);
  assert_setup_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(astb) |-> $past(ad_oe));

  assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_lo_n) || $fell(wr_hi_n)) |-> $past(!astb && ad_oe));

  assert_strobe_under_astb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(astb && (!rd_n || !wr_lo_n || !wr_hi_n)));

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_lo_n && wr_hi_n));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_float_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!ad_oe && !ctl_oe));

  assert_float_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(!ad_oe && !ctl_oe));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

  assert_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!req_ready && astb));
endmodule

bind mxb_bus_master mxb_bus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .astb(astb), .rd_n(rd_n),
  .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .ctl_oe(ctl_oe), .hold_req(hold_req),
  .hold_ack(hold_ack), .req_ready(req_ready), .rsp_done(rsp_done)
);

// File: tb/mxb_bus_master_bench.sv
module mxb_bus_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int WW = 2;

  logic          clk, rst_n;
  logic          cfg_as, cfg_ah, cfg_idle;
  logic [WW-1:0] cfg_wait;
  logic          req_valid, req_ready, req_wr;
  logic [DW-1:0] req_addr, req_wdata, rsp_data, ad_in, ad_out;
  logic [1:0]    req_be;
  logic          rsp_done, ad_oe, astb, rd_n, wr_lo_n, wr_hi_n, ctl_oe;
  logic          wait_req, hold_req, hold_ack;

  int n_chk = 0;
  int n_fail = 0;

  mxb_bus_master #(.DW(DW), .WW(WW)) u_mxb_bus_master (
    .clk(clk), .rst_n(rst_n), .cfg_as(cfg_as), .cfg_ah(cfg_ah),
    .cfg_idle(cfg_idle), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_ready(req_ready), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .astb(astb), .rd_n(rd_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
    .ctl_oe(ctl_oe), .wait_req(wait_req), .hold_req(hold_req),
    .hold_ack(hold_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic run_xfer(input bit wr, input logic [DW-1:0] addr,
                          input logic [DW-1:0] data, input logic [1:0] be,
                          input bit as, input bit ah, input bit idl,
                          input logic [WW-1:0] cw, input int x);
    int n;
    int len;
    int r;
    bit fin;
    logic [DW-1:0] pat;
    pat = ~addr ^ {data[7:0], data[15:8]};
    ad_in = pat;
    req_wr = wr; req_addr = addr; req_wdata = data; req_be = be;
    cfg_as = as; cfg_ah = ah; cfg_idle = idl; cfg_wait = cw;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R1: address setup phase
    n = 0;
    while (astb && n < 20) begin
      n++;
      chk(ad_oe && ad_out == addr && !hold_ack, "R1 setup drive", int'(ad_out), int'(addr));
      @(negedge clk);
    end
    chk(n == 1 + 2 * as, "R1 setup ticks", n, 1 + 2 * as);
    // R2: address hold phase
    n = 0;
    while (rd_n && wr_lo_n && wr_hi_n && n < 20) begin
      n++;
      chk(!astb && ad_oe && ad_out == addr, "R2 hold drive", int'(ad_out), int'(addr));
      @(negedge clk);
    end
    chk(n == 1 + 2 * ah, "R2 hold ticks", n, 1 + 2 * ah);
    // R3: strobe width with sampled waits
    n = 0;
    while ((!rd_n || !wr_lo_n || !wr_hi_n) && n < 40) begin
      n++;
      wait_req = (n <= x);
      chk(!astb, "R4 astb low under strobe", int'(astb), 0);
      if (wr)
        chk(rd_n && wr_lo_n == !be[0] && wr_hi_n == !be[1] && ad_oe && ad_out == data,
            "R6 write strobe lanes/data", int'({rd_n, wr_hi_n, wr_lo_n, ad_oe}),
            int'({1'b1, !be[1], !be[0], 1'b1}));
      else
        chk(!ad_oe && wr_lo_n && wr_hi_n, "R5 read strobe float",
            int'({ad_oe, wr_hi_n, wr_lo_n}), 3);
      @(negedge clk);
    end
    wait_req = 1'b0;
    len = 2 * (1 + int'(cw));
    while (len <= x) len += 2;
    chk(n == len, "R3 strobe ticks", n, len);
    // R4/R5/R6: recovery
    r = 0;
    fin = 1'b0;
    while (!fin && r < 20) begin
      r++;
      chk(astb == (r > 1), "R4 astb after strobe", int'(astb), int'(r > 1));
      if (wr) chk(ad_oe && ad_out == data, "R6 write data hold", int'(ad_out), int'(data));
      else    chk(!ad_oe, "R5 read recovery float", int'(ad_oe), 0);
      if (rsp_done) fin = 1'b1;
      else @(negedge clk);
    end
    if (wr) chk(r == 2, "R6 write recovery ticks", r, 2);
    else begin
      chk(r == 2 + 2 * idl, "R5 read recovery ticks", r, 2 + 2 * idl);
      chk(rsp_data == pat, "R5 read data", int'(rsp_data), int'(pat));
    end
    @(negedge clk);
    chk(!rsp_done, "R7 done single tick", int'(rsp_done), 0);
    if (!hold_req) chk(req_ready, "R7 ready after done", int'(req_ready), 1);
  endtask

  task automatic hold_cycle(input bit fresh);
    int k;
    bit prev_float;
    if (fresh) hold_req = 1'b1;
    k = 0;
    prev_float = !ctl_oe && !ad_oe;
    while (!hold_ack && k < 30) begin
      prev_float = !ctl_oe && !ad_oe;
      chk(!fresh || astb, "R10 no start while pending", int'(astb), 1);
      @(negedge clk);
      k++;
    end
    chk(hold_ack, "R8 ack granted", int'(hold_ack), 1);
    chk(prev_float, "R8 float before ack", int'(prev_float), 1);
    if (fresh) chk(k >= 4, "R8 ack delay", k, 4);
    for (int i = 0; i < 3; i++) begin
      chk(!req_ready && astb && !ad_oe && !ctl_oe, "R10 bus released",
          int'({req_ready, astb, ad_oe, ctl_oe}), 4);
      @(negedge clk);
    end
    hold_req = 1'b0;
    @(negedge clk);
    chk(!hold_ack && !ctl_oe, "R9 ack drop", int'({hold_ack, ctl_oe}), 0);
    @(negedge clk);
    chk(ctl_oe && !hold_ack, "R9 outputs return", int'({ctl_oe, hold_ack}), 2);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; req_be = 2'b00;
    cfg_as = 1'b0; cfg_ah = 1'b0; cfg_idle = 1'b0; cfg_wait = '0;
    ad_in = '0; wait_req = 1'b0; hold_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(astb && rd_n && wr_lo_n && wr_hi_n && ctl_oe && !ad_oe && !hold_ack && !rsp_done,
        "R11 reset outputs",
        int'({astb, rd_n, wr_lo_n, wr_hi_n, ctl_oe, ad_oe, hold_ack, rsp_done}), 8'hF8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R7 ready after reset", int'(req_ready), 1);

    for (int wr = 0; wr < 2; wr++)
      for (int cfg = 0; cfg < 8; cfg++)
        for (int cw = 0; cw < 4; cw++)
          for (int xs = 0; xs < 3; xs++) begin
            int xv;
            xv = (xs == 0) ? 0 : (xs == 1) ? 2 * (1 + cw) : 2 * (1 + cw) + 3;
            run_xfer(wr[0], 16'(16'h1200 + cfg * 64 + cw * 4 + xs),
                     16'(16'hA500 ^ (cfg * 257 + cw * 17 + xs)),
                     2'((cfg + cw + xs) % 3 + 1),
                     cfg[0], cfg[1], cfg[2], WW'(cw), xv);
          end

    // R10: request pending while bus released, then carried out
    @(negedge clk);
    req_wr = 1'b1; req_addr = 16'h0BEE; req_wdata = 16'h5A5A; req_be = 2'b10;
    req_valid = 1'b1;
    hold_cycle(1'b1);
    run_xfer(1'b1, 16'h0BEE, 16'h5A5A, 2'b10, 1'b1, 1'b0, 1'b0, 2'd1, 0);

    // R8: hold requested mid-transfer, granted only afterwards
    fork
      run_xfer(1'b0, 16'h3C3C, 16'h0000, 2'b11, 1'b0, 1'b1, 1'b1, 2'd2, 0);
      begin
        repeat (4) @(negedge clk);
        hold_req = 1'b1;
      end
    join
    hold_cycle(1'b0);
    run_xfer(1'b1, 16'h7001, 16'h1357, 2'b01, 1'b0, 1'b0, 1'b0, 2'd0, 0);

    summary();
    $finish;
  end
endmodule